// File: doc/BRIEF.md
# Four-Term Scaled Depth Averaging Unit

This block forms a scaled sum of four unsigned 16-bit depth samples. All four use one shared signed scale factor. The scale factor has 1 sign bit, 3 integer bits and 12 fraction bits. The sum is kept at full precision in a 64-bit signed accumulator, so no partial sum wraps. From that sum the block produces three results:

- a 32-bit two's-complement accumulator word;
- a 16-bit ordering depth: the sum shifted right by 12 and clamped to 0..65535;
- a 32-bit status word that records overflow and clamp events.

A client pulses `start_i` while the unit is idle, with the operands valid on that edge. The unit latches the operands and clears its status word. It then adds one product per clock over four clocks and spends one clock on the range checks and the clamp. On the sixth clock edge after the accepting edge it writes all three outputs together and raises `done_o` for one cycle. A `start_i` pulse seen while the unit is busy changes nothing.

Top module: `depth_avg4_unit`

## Requirements
- R1: On an accepted start, `scale_i` is taken as a signed value with 12 fraction bits. `depth_i` is taken as four unsigned 16-bit lanes, lane k at bits [16k+15:16k].
- R2: `acc_o` equals the low 32 bits, in two's complement, of the exact sum of scale × depth over the four lanes.
- R3: `otz_o` equals the exact sum shifted right arithmetically by 12, then clamped to 0..65535.
- R4: Status bit 16 is set exactly when the exact sum is greater than or equal to 2^31.
- R5: Status bit 15 is set exactly when the exact sum is less than -2^31.
- R6: Status bit 18 is set exactly when the shifted sum lies below 0 or above 65535.
- R7: Status bit 31 equals the OR of bits 15, 16 and 18. Every other status bit reads 0.
- R8: In the cycle after an accepted start, `flag_o` reads 0 and `busy_o` reads 1.
- R9: `done_o` goes high for exactly one cycle, on the sixth rising edge after the accepting edge. In that same cycle `busy_o` falls and all three outputs take their new values.
- R10: A start pulse while `busy_o` is high is ignored. The running operation finishes with its original operands, and only one `done_o` pulse follows.
- R11: While reset is asserted, `busy_o`, `done_o`, `acc_o`, `otz_o` and `flag_o` read 0, and any operation in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, honoured only when idle |
| scale_i | input | 16 | Signed scale, 12 fraction bits |
| depth_i | input | 64 | Four unsigned 16-bit depth lanes |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse when results are written |
| acc_o | output | 32 | Low 32 bits of the exact scaled sum |
| otz_o | output | 16 | Clamped ordering depth |
| flag_o | output | 32 | Status word (bits 15, 16, 18, 31) |

## Verification
The assertions assume three things about the inputs. After reset, `start_i` is a known synchronous level. The operands are valid on the edge that accepts a start. Nothing but reset disturbs a sequence once it is running. The stimulus drives `start_i`, `scale_i` and `depth_i` only on falling clock edges and holds each start pulse for one cycle. Operands may change freely while the unit is busy, because the unit latched its copy at acceptance. Sums are chosen to land exactly on ±2^31 and on either side of them, and on the 65535 clamp edge, so that each range comparison is driven at its boundary.

// File: rtl/avg4_pkg.sv
package avg4_pkg;

    localparam int FLAG_W      = 32;
    localparam int FLG_NEG_OVF = 15;
    localparam int FLG_POS_OVF = 16;
    localparam int FLG_SAT     = 18;
    localparam int FLG_ERR     = 31;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACCUM,
        ST_CHECK,
        ST_COMMIT
    } seq_state_e;

endpackage

// File: rtl/avg4_ctrl.sv
module avg4_ctrl
    import avg4_pkg::*;
#(
    parameter  int NUM_TERMS = 4,
    localparam int IDX_W     = (NUM_TERMS > 1) ? $clog2(NUM_TERMS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             busy_o,
    output logic             load_o,
    output logic             acc_en_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             check_en_o,
    output logic             commit_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_TERMS - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [IDX_W-1:0] idx;
    } ctrl_s;

    ctrl_s c_d, c_q;

    always_comb begin
        c_d        = c_q;
        load_o     = 1'b0;
        acc_en_o   = 1'b0;
        check_en_o = 1'b0;
        commit_o   = 1'b0;
        case (c_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    load_o    = 1'b1;
                    c_d.state = ST_ACCUM;
                    c_d.idx   = '0;
                end
            end
            ST_ACCUM: begin
                acc_en_o = 1'b1;
                if (c_q.idx == LAST_IDX) begin
                    c_d.state = ST_CHECK;
                end else begin
                    c_d.idx = c_q.idx + 1'b1;
                end
            end
            ST_CHECK: begin
                check_en_o = 1'b1;
                c_d.state  = ST_COMMIT;
            end
            ST_COMMIT: begin
                commit_o  = 1'b1;
                c_d.state = ST_IDLE;
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.state <= ST_IDLE;
            c_q.idx   <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign busy_o = (c_q.state != ST_IDLE);
    assign idx_o  = c_q.idx;

    // R9: the last accumulate step is followed by the check step
    p_accum_to_check_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en_o && c_q.idx == LAST_IDX) |=> check_en_o);

    // R9: a commit returns the sequencer to idle
    p_commit_to_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !busy_o);

endmodule

// File: rtl/avg4_mac.sv
module avg4_mac #(
    parameter  int DEPTH_W   = 16,
    parameter  int SCALE_W   = 16,
    parameter  int NUM_TERMS = 4,
    parameter  int SUM_W     = 64,
    localparam int IDX_W     = (NUM_TERMS > 1) ? $clog2(NUM_TERMS) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clear_i,
    input  logic                           en_i,
    input  logic [IDX_W-1:0]               idx_i,
    input  logic [SCALE_W-1:0]             scale_i,
    input  logic [NUM_TERMS*DEPTH_W-1:0]   depths_i,
    output logic signed [SUM_W-1:0]        sum_o
);

    localparam int PROD_W = SCALE_W + DEPTH_W + 1;

    logic [DEPTH_W-1:0]       lane [NUM_TERMS];
    logic [DEPTH_W-1:0]       pick;
    logic signed [PROD_W-1:0] prod;
    logic signed [SUM_W-1:0]  sum_d, sum_q;

    for (genvar k = 0; k < NUM_TERMS; k++) begin : g_lane
        assign lane[k] = depths_i[k*DEPTH_W +: DEPTH_W];
    end

    assign pick = lane[idx_i];
    assign prod = PROD_W'($signed(scale_i)) * PROD_W'($signed({1'b0, pick}));

    always_comb begin
        sum_d = sum_q;
        if (clear_i) begin
            sum_d = '0;
        end else if (en_i) begin
            sum_d = sum_q + SUM_W'(prod);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else begin
            sum_q <= sum_d;
        end
    end

    assign sum_o = sum_q;

endmodule

// File: rtl/avg4_limit.sv
module avg4_limit
    import avg4_pkg::*;
#(
    parameter int SUM_W  = 64,
    parameter int FRAC_W = 12,
    parameter int ACC_W  = 32,
    parameter int OTZ_W  = 16
) (
    input  logic signed [SUM_W-1:0] sum_i,
    output logic [ACC_W-1:0]        acc_o,
    output logic [OTZ_W-1:0]        otz_o,
    output logic [FLAG_W-1:0]       flag_o
);

    localparam logic signed [SUM_W-1:0] POS_LIM = SUM_W'(1) << (ACC_W - 1);
    localparam logic signed [SUM_W-1:0] NEG_LIM = -POS_LIM;
    localparam logic signed [SUM_W-1:0] OTZ_MAX =
        {{(SUM_W-OTZ_W){1'b0}}, {OTZ_W{1'b1}}};

    logic signed [SUM_W-1:0] scaled;
    logic pos_ovf, neg_ovf, sat_lo, sat_hi;

    always_comb begin
        scaled  = sum_i >>> FRAC_W;
        pos_ovf = (sum_i >= POS_LIM);
        neg_ovf = (sum_i < NEG_LIM);
        sat_lo  = (scaled < 0);
        sat_hi  = (scaled > OTZ_MAX);

        if (sat_lo) begin
            otz_o = '0;
        end else if (sat_hi) begin
            otz_o = '1;
        end else begin
            otz_o = scaled[OTZ_W-1:0];
        end

        flag_o              = '0;
        flag_o[FLG_POS_OVF] = pos_ovf;
        flag_o[FLG_NEG_OVF] = neg_ovf;
        flag_o[FLG_SAT]     = sat_lo | sat_hi;
        flag_o[FLG_ERR]     = pos_ovf | neg_ovf | sat_lo | sat_hi;

        acc_o = sum_i[ACC_W-1:0];
    end

endmodule

// File: rtl/depth_avg4_unit.sv
module depth_avg4_unit
    import avg4_pkg::*;
#(
    parameter int DEPTH_W   = 16,
    parameter int SCALE_W   = 16,
    parameter int FRAC_W    = 12,
    parameter int NUM_TERMS = 4,
    parameter int ACC_W     = 32,
    parameter int OTZ_W     = 16,
    parameter int SUM_W     = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic [SCALE_W-1:0]           scale_i,
    input  logic [NUM_TERMS*DEPTH_W-1:0] depth_i,
    output logic                         busy_o,
    output logic                         done_o,
    output logic [ACC_W-1:0]             acc_o,
    output logic [OTZ_W-1:0]             otz_o,
    output logic [FLAG_W-1:0]            flag_o
);

    localparam int DEPTHS_W = NUM_TERMS * DEPTH_W;
    localparam int IDX_W    = (NUM_TERMS > 1) ? $clog2(NUM_TERMS) : 1;

    typedef struct packed {
        logic [SCALE_W-1:0]  scale;
        logic [DEPTHS_W-1:0] depths;
        logic [ACC_W-1:0]    st_acc;
        logic [OTZ_W-1:0]    st_otz;
        logic [FLAG_W-1:0]   st_flag;
        logic [ACC_W-1:0]    acc;
        logic [OTZ_W-1:0]    otz;
        logic [FLAG_W-1:0]   flag;
        logic                done;
    } unit_s;

    unit_s r_d, r_q;

    logic                    load, acc_en, check_en, commit;
    logic [IDX_W-1:0]        idx;
    logic signed [SUM_W-1:0] sum;
    logic [ACC_W-1:0]        lim_acc;
    logic [OTZ_W-1:0]        lim_otz;
    logic [FLAG_W-1:0]       lim_flag;

    avg4_ctrl #(
        .NUM_TERMS (NUM_TERMS)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .busy_o     (busy_o),
        .load_o     (load),
        .acc_en_o   (acc_en),
        .idx_o      (idx),
        .check_en_o (check_en),
        .commit_o   (commit)
    );

    avg4_mac #(
        .DEPTH_W   (DEPTH_W),
        .SCALE_W   (SCALE_W),
        .NUM_TERMS (NUM_TERMS),
        .SUM_W     (SUM_W)
    ) u_mac (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (load),
        .en_i     (acc_en),
        .idx_i    (idx),
        .scale_i  (r_q.scale),
        .depths_i (r_q.depths),
        .sum_o    (sum)
    );

    avg4_limit #(
        .SUM_W  (SUM_W),
        .FRAC_W (FRAC_W),
        .ACC_W  (ACC_W),
        .OTZ_W  (OTZ_W)
    ) u_limit (
        .sum_i  (sum),
        .acc_o  (lim_acc),
        .otz_o  (lim_otz),
        .flag_o (lim_flag)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (load) begin
            r_d.scale  = scale_i;
            r_d.depths = depth_i;
            r_d.flag   = '0;
        end
        if (check_en) begin
            r_d.st_acc  = lim_acc;
            r_d.st_otz  = lim_otz;
            r_d.st_flag = lim_flag;
        end
        if (commit) begin
            r_d.acc  = r_q.st_acc;
            r_d.otz  = r_q.st_otz;
            r_d.flag = r_q.st_flag;
            r_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign done_o = r_q.done;
    assign acc_o  = r_q.acc;
    assign otz_o  = r_q.otz;
    assign flag_o = r_q.flag;

    // R9: done lasts a single cycle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: accepted start clears status and marks busy
    p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (flag_o == '0) && busy_o);

    // R10: operands are frozen while busy
    p_ignore_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o) |=> $stable(r_q.scale) && $stable(r_q.depths));

    // R7: summary bit tracks the error bits at every result
    p_err_summary_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> flag_o[FLG_ERR] ==
                   (flag_o[FLG_NEG_OVF] | flag_o[FLG_POS_OVF] | flag_o[FLG_SAT]));

    // R4 R5: the two overflow directions never coexist
    p_ovf_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !(flag_o[FLG_NEG_OVF] && flag_o[FLG_POS_OVF]));

    // R3: an unclamped ordering depth is the scaled slice of the accumulator
    p_otz_matches_acc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !flag_o[FLG_SAT]) |->
            (otz_o == acc_o[FRAC_W+OTZ_W-1:FRAC_W]) &&
            (acc_o[ACC_W-1:FRAC_W+OTZ_W] == '0));

endmodule

// File: tb/depth_avg4_unit_test.sv
`timescale 1ns/1ps
module depth_avg4_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] scale_i = '0;
    logic [63:0] depth_i = '0;
    logic        busy_o, done_o;
    logic [31:0] acc_o, flag_o;
    logic [15:0] otz_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    depth_avg4_unit uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .scale_i (scale_i),
        .depth_i (depth_i),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .acc_o   (acc_o),
        .otz_o   (otz_o),
        .flag_o  (flag_o)
    );

    typedef struct packed {
        logic [15:0] scale;
        logic [15:0] d0;
        logic [15:0] d1;
        logic [15:0] d2;
        logic [15:0] d3;
        logic [31:0] flag;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{16'h0000, 16'd0,     16'd0,     16'd0,    16'd0,     32'h0000_0000},
        '{16'h1000, 16'd100,   16'd200,   16'd300,  16'd400,   32'h0000_0000},
        '{16'h0400, 16'd1000,  16'd2000,  16'd3000, 16'd4000,  32'h0000_0000},
        '{16'h7FFF, 16'hFFFF,  16'hFFFF,  16'hFFFF, 16'hFFFF,  32'h8005_0000},
        '{16'hF000, 16'd10,    16'd20,    16'd30,   16'd40,    32'h8004_0000},
        '{16'h4000, 16'hFFFF,  16'hFFFF,  16'd1,    16'd1,     32'h8005_0000},
        '{16'hC000, 16'hFFFF,  16'hFFFF,  16'd1,    16'd1,     32'h8004_0000},
        '{16'hC000, 16'hFFFF,  16'hFFFF,  16'd1,    16'd2,     32'h8004_8000},
        '{16'h4000, 16'hFFFF,  16'hFFFF,  16'd1,    16'd0,     32'h8004_0000},
        '{16'h8000, 16'hFFFF,  16'hFFFF,  16'hFFFF, 16'hFFFF,  32'h8004_8000},
        '{16'h1000, 16'hFFFF,  16'd0,     16'd0,    16'd0,     32'h0000_0000},
        '{16'h1000, 16'hFFFF,  16'd1,     16'd0,    16'd0,     32'h8004_0000},
        '{16'hFFFF, 16'd1,     16'd0,     16'd0,    16'd0,     32'h8004_0000},
        '{16'h0001, 16'd4095,  16'd0,     16'd0,    16'd0,     32'h0000_0000},
        '{16'h8000, 16'd0,     16'd0,     16'd0,    16'd0,     32'h0000_0000}
    };

    function automatic longint ref_sum(input logic [15:0] sc,
                                       input logic [15:0] a, b, c, d);
        longint s;
        s = longint'($signed(sc));
        return s * (longint'(a) + longint'(b) + longint'(c) + longint'(d));
    endfunction

    function automatic logic [15:0] ref_otz(input longint s);
        longint sh;
        sh = s >>> 12;
        if (sh < 0) return 16'd0;
        if (sh > 65535) return 16'hFFFF;
        return sh[15:0];
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Pulse start on a falling edge, then wait for done; lat counts falling
    // edges after the accepting rising edge (7 means done after the 6th edge).
    task automatic run_op(input logic [15:0] sc, input logic [15:0] a, b, c, d,
                          output int lat);
        @(negedge clk);
        scale_i = sc;
        depth_i = {d, c, b, a};
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        while (!done_o && lat < 20) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int lat;
        longint s;
        int pulses;

        // R11: reset state
        repeat (3) @(negedge clk);
        chk("R11 busy in reset", 64'(busy_o), 64'd0);
        chk("R11 done in reset", 64'(done_o), 64'd0);
        chk("R11 acc in reset",  64'(acc_o),  64'd0);
        chk("R11 otz in reset",  64'(otz_o),  64'd0);
        chk("R11 flag in reset", 64'(flag_o), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table: R1 R2 R3 R4 R5 R6 R7 R9
        for (int i = 0; i < NV; i++) begin
            run_op(VECS[i].scale, VECS[i].d0, VECS[i].d1, VECS[i].d2, VECS[i].d3, lat);
            s = ref_sum(VECS[i].scale, VECS[i].d0, VECS[i].d1, VECS[i].d2, VECS[i].d3);
            chk("R9 latency",         64'(lat),    64'd7);
            chk("R9 busy low at done", 64'(busy_o), 64'd0);
            chk("R1 R2 acc",          64'(acc_o),  64'(s[31:0]));
            chk("R3 otz",             64'(otz_o),  64'(ref_otz(s)));
            chk("R4 R5 R6 R7 flag",   64'(flag_o), 64'(VECS[i].flag));
            @(negedge clk);
            chk("R9 done single cycle", 64'(done_o), 64'd0);
        end

        // R8: status cleared after an accepted start that follows an overflow
        run_op(16'h7FFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, lat);
        chk("R8 flag before restart", 64'(flag_o), 64'h8005_0000);
        @(negedge clk);
        scale_i = 16'h1000;
        depth_i = {16'd0, 16'd0, 16'd0, 16'd5};
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R8 flag cleared", 64'(flag_o), 64'd0);
        chk("R8 busy set",     64'(busy_o), 64'd1);
        while (!done_o) @(negedge clk);
        chk("R8 following result otz", 64'(otz_o), 64'd5);

        // R10: a start while busy is ignored
        @(negedge clk);
        scale_i = 16'h1000;
        depth_i = {16'd4, 16'd3, 16'd2, 16'd1};
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        scale_i = 16'h7FFF;
        depth_i = '1;
        @(negedge clk);
        chk("R10 busy while second start", 64'(busy_o), 64'd1);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        pulses = 0;
        for (int k = 0; k < 14; k++) begin
            if (done_o) begin
                pulses++;
                chk("R10 acc keeps original operands",  64'(acc_o),  64'd40960);
                chk("R10 otz keeps original operands",  64'(otz_o),  64'd10);
                chk("R10 flag keeps original operands", 64'(flag_o), 64'd0);
            end
            @(negedge clk);
        end
        chk("R10 single done pulse", 64'(pulses), 64'd1);

        // R11: reset during an operation abandons it
        @(negedge clk);
        scale_i = 16'h7FFF;
        depth_i = '1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11 busy after mid reset", 64'(busy_o), 64'd0);
        chk("R11 acc after mid reset",  64'(acc_o),  64'd0);
        chk("R11 flag after mid reset", 64'(flag_o), 64'd0);
        rst_n = 1'b1;
        pulses = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (done_o) pulses++;
        end
        chk("R11 no done after abandon", 64'(pulses), 64'd0);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule